// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic core of a small 8-bit controller. Each cycle with `en_i` high, it takes an operation code, two operand bytes and one extra bit. It then updates its registered result bytes and its registered carry, auxiliary-carry and overflow flags. The parity output follows the registered accumulator result at all times.

Add, add-with-carry and subtract-with-borrow read the stored carry flag as the incoming carry or borrow. Multiply and divide return their 16-bit or quotient/remainder results across the two result bytes. Two Boolean operations treat the carry flag as a one-bit accumulator and combine it with `bit_i`.

The block does not fetch operands or decode instructions. It also does not hold any storage beyond its result and flag registers.

Top module: `alu8_core`

## Requirements
- R1: While `rst_ni` is low, `acc_o`, `b_o`, `cy_o`, `ac_o`, `ov_o` and `parity_o` are all 0.
- R2: For op 3'd0 (add) and op 3'd1 (add with carry), `acc_o` becomes the low byte of `a_i + b_i`, plus the stored carry for op 3'd1. `cy_o` becomes bit 8 of that sum, and `b_o` is unchanged.
- R3: For add operations, `ac_o` is set when the sum produces a carry out of bit 3. For op 3'd2, `ac_o` is set when the low nibble needs a borrow.
- R4: For ops 3'd0, 3'd1 and 3'd2, `ov_o` is set when the signed result lies outside -128..+127.
- R5: For op 3'd2 (subtract with borrow), `acc_o` becomes `a_i - b_i - cy` modulo 256. `cy_o` is set when a borrow was needed, and `b_o` is unchanged.
- R6: `parity_o` is set exactly when `acc_o` holds an odd number of ones, so that the accumulator and the parity bit together hold an even count.
- R7: For op 3'd3 (multiply), `{b_o, acc_o}` becomes `a_i * b_i`. `cy_o` is cleared, `ov_o` is set when the product exceeds 8'hFF, and `ac_o` is unchanged.
- R8: For op 3'd4 (divide) with a nonzero `b_i`, `acc_o` becomes the quotient and `b_o` the remainder. `cy_o` and `ov_o` are cleared, and `ac_o` is unchanged.
- R9: For op 3'd4 with `b_i` equal to 0, `ov_o` is set, `cy_o` is cleared, and `acc_o` and `b_o` keep their previous values.
- R10: Op 3'd5 sets `cy_o` to `cy_o & bit_i` and op 3'd6 sets it to `cy_o | bit_i`. For both, `acc_o`, `b_o`, `ac_o` and `ov_o` are unchanged.
- R11: When `en_i` is low, or when the op is 3'd7 (no operation), no output register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Execute the operation on this cycle |
| op_i | input | 3 | Operation code |
| a_i | input | 8 | First operand (accumulator value) |
| b_i | input | 8 | Second operand |
| bit_i | input | 1 | Single bit for the carry Boolean operations |
| acc_o | output | 8 | Result low byte / quotient |
| b_o | output | 8 | Result high byte / remainder |
| cy_o | output | 1 | Carry / borrow flag |
| ac_o | output | 1 | Auxiliary carry flag |
| ov_o | output | 1 | Overflow flag |
| parity_o | output | 1 | Parity of the accumulator result |

## Verification
The vector sequence chains its operations so that each carry-using step depends on the carry left by the step before. Additions are chosen to separate the unsigned wrap (FF+01) from the signed overflow (7F+01) and from a carry produced only out of the low nibble. Subtractions cover a plain borrow, a signed overflow with a borrow coming in, and a zero result. Multiply uses products on both sides of FFh, and divide covers a normal case, a zero quotient and a zero divisor; Boolean steps toggle the carry both ways before a disabled cycle and a no-op show that nothing moves.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4,
    OP_ANLC = 3'd5,
    OP_ORLC = 3'd6,
    OP_NOP  = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ac_o,
  output logic         ov_o
);
  localparam int H = W / 2;

  logic [W-1:0] b_eff;
  logic         c0;
  logic [H:0]   low_sum;
  logic [W-1:0] msb_in_sum;
  logic [W:0]   full_sum;

  // subtraction as a + ~b + ~borrow; carries come out inverted
  always_comb begin
    b_eff      = sub_i ? ~b_i : b_i;
    c0         = sub_i ? ~cin_i : cin_i;
    low_sum    = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c0};
    msb_in_sum = {1'b0, a_i[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, c0};
    full_sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c0};
    res_o      = full_sum[W-1:0];
    cy_o       = sub_i ? ~full_sum[W] : full_sum[W];
    ac_o       = sub_i ? ~low_sum[H] : low_sum[H];
    ov_o       = full_sum[W] ^ msb_in_sum[W-1];
  end
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  assign prod_o = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
endmodule

// File: rtl/alu8_div.sv
module alu8_div #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] rem_s [W+1];

  assign rem_s[0] = '0;

  // restoring division, one stage per dividend bit, MSB first
  for (genvar k = 0; k < W; k++) begin : g_stage
    localparam int IDX = W - 1 - k;
    logic [W:0] part;
    logic [W:0] trial;
    assign part  = {rem_s[k], a_i[IDX]};
    assign trial = part - {1'b0, b_i};
    assign quo_o[IDX] = ~trial[W];
    assign rem_s[k+1] = trial[W] ? part[W-1:0] : trial[W-1:0];
  end

  assign rem_o = rem_s[W];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         bit_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] b_o,
  output logic         cy_o,
  output logic         ac_o,
  output logic         ov_o,
  output logic         parity_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [W-1:0]   as_res;
  logic           as_cy, as_ac, as_ov;
  logic [2*W-1:0] prod;
  logic [W-1:0]   quo, rem;
  logic           is_sub, use_c;

  assign is_sub = (op == OP_SUBB);
  assign use_c  = (op == OP_ADDC) || (op == OP_SUBB);

  alu8_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .cin_i(use_c & cy_o), .sub_i(is_sub),
    .res_o(as_res), .cy_o(as_cy), .ac_o(as_ac), .ov_o(as_ov)
  );

  alu8_mul #(.W(W)) u_mul (.a_i(a_i), .b_i(b_i), .prod_o(prod));

  alu8_div #(.W(W)) u_div (.a_i(a_i), .b_i(b_i), .quo_o(quo), .rem_o(rem));

  logic [W-1:0] acc_d, b_d;
  logic         cy_d, ac_d, ov_d;

  always_comb begin
    acc_d = acc_o;
    b_d   = b_o;
    cy_d  = cy_o;
    ac_d  = ac_o;
    ov_d  = ov_o;
    if (en_i) begin
      unique case (op)
        OP_ADD, OP_ADDC, OP_SUBB: begin
          acc_d = as_res;
          cy_d  = as_cy;
          ac_d  = as_ac;
          ov_d  = as_ov;
        end
        OP_MUL: begin
          acc_d = prod[W-1:0];
          b_d   = prod[2*W-1:W];
          cy_d  = 1'b0;
          ov_d  = |prod[2*W-1:W];
        end
        OP_DIV: begin
          cy_d = 1'b0;
          ov_d = ~|b_i;
          if (|b_i) begin
            acc_d = quo;
            b_d   = rem;
          end
        end
        OP_ANLC: cy_d = cy_o & bit_i;
        OP_ORLC: cy_d = cy_o | bit_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      b_o   <= '0;
      cy_o  <= 1'b0;
      ac_o  <= 1'b0;
      ov_o  <= 1'b0;
    end else begin
      acc_o <= acc_d;
      b_o   <= b_d;
      cy_o  <= cy_d;
      ac_o  <= ac_d;
      ov_o  <= ov_d;
    end
  end

  assign parity_o = ^acc_o;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         bit_i,
  input logic [W-1:0] acc_o,
  input logic [W-1:0] b_o,
  input logic         cy_o,
  input logic         ac_o,
  input logic         ov_o,
  input logic         parity_o
);
  // R2
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 3'd0) |=> ({cy_o, acc_o} == {1'b0, $past(a_i)} + {1'b0, $past(b_i)}));

  // R6
  parity_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({acc_o, parity_o}) % 2) == 0);

  // R7
  mul_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 3'd3) |=>
      ({b_o, acc_o} == {{W{1'b0}}, $past(a_i)} * {{W{1'b0}}, $past(b_i)}) && !cy_o
      && (ov_o == (b_o != '0)) && (ac_o == $past(ac_o)));

  // R8
  div_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 3'd4 && b_i != '0) |=>
      (({{W{1'b0}}, $past(b_i)} * {{W{1'b0}}, acc_o} + {{W{1'b0}}, b_o})
        == {{W{1'b0}}, $past(a_i)}) && (b_o < $past(b_i)) && !cy_o && !ov_o);

  // R9
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 3'd4 && b_i == '0) |=>
      ov_o && !cy_o && $stable(acc_o) && $stable(b_o));

  // R10
  bool_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op_i == 3'd5 || op_i == 3'd6)) |=>
      (cy_o == ($past(op_i) == 3'd5 ? ($past(cy_o) & $past(bit_i))
                                    : ($past(cy_o) | $past(bit_i))))
      && $stable(acc_o) && $stable(b_o) && $stable(ac_o) && $stable(ov_o));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || op_i == 3'd7) |=>
      $stable(acc_o) && $stable(b_o) && $stable(cy_o) && $stable(ac_o) && $stable(ov_o));
endmodule

bind alu8_core alu8_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .bit_i(bit_i), .acc_o(acc_o), .b_o(b_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
  .parity_o(parity_o)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [2:0] op_i = 3'd7;
  logic [7:0] a_i = '0, b_i = '0;
  logic       bit_i = 1'b0;
  logic [7:0] acc_o, b_o;
  logic       cy_o, ac_o, ov_o, parity_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  alu8_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .bit_i(bit_i), .acc_o(acc_o), .b_o(b_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
    .parity_o(parity_o)
  );

  // {op, a, b, bit, exp_acc, exp_b, exp_cy, exp_ac, exp_ov}; carry flows between rows
  localparam int N = 17;
  localparam logic [38:0] VEC [N] = '{
    {3'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 8'h00, 3'b110},
    {3'd1, 8'h10, 8'h20, 1'b0, 8'h31, 8'h00, 3'b000},
    {3'd0, 8'h7F, 8'h01, 1'b0, 8'h80, 8'h00, 3'b011},
    {3'd2, 8'h00, 8'h01, 1'b0, 8'hFF, 8'h00, 3'b110},
    {3'd2, 8'h80, 8'h01, 1'b0, 8'h7E, 8'h00, 3'b011},
    {3'd3, 8'h10, 8'h10, 1'b0, 8'h00, 8'h01, 3'b011},
    {3'd3, 8'h0C, 8'h0D, 1'b0, 8'h9C, 8'h00, 3'b010},
    {3'd6, 8'h00, 8'h00, 1'b1, 8'h9C, 8'h00, 3'b110},
    {3'd5, 8'h00, 8'h00, 1'b0, 8'h9C, 8'h00, 3'b010},
    {3'd6, 8'h00, 8'h00, 1'b1, 8'h9C, 8'h00, 3'b110},
    {3'd5, 8'h00, 8'h00, 1'b1, 8'h9C, 8'h00, 3'b110},
    {3'd4, 8'hFB, 8'h12, 1'b0, 8'h0D, 8'h11, 3'b010},
    {3'd4, 8'h07, 8'h09, 1'b0, 8'h00, 8'h07, 3'b010},
    {3'd4, 8'h05, 8'h00, 1'b0, 8'h00, 8'h07, 3'b011},
    {3'd0, 8'h08, 8'h08, 1'b0, 8'h10, 8'h07, 3'b010},
    {3'd2, 8'h45, 8'h45, 1'b0, 8'h00, 8'h07, 3'b000},
    {3'd7, 8'h12, 8'h34, 1'b0, 8'h00, 8'h07, 3'b000}
  };

  function automatic string tag_of(input logic [2:0] op, input logic [7:0] b);
    case (op)
      3'd0, 3'd1: return "R2 R3 R4";
      3'd2:       return "R5 R3 R4";
      3'd3:       return "R7";
      3'd4:       return (b == 8'h00) ? "R9" : "R8";
      3'd5, 3'd6: return "R10";
      default:    return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [7:0] ea, input logic [7:0] eb,
                             input logic [2:0] ef);
    check({acc_o, b_o, cy_o, ac_o, ov_o} == {ea, eb, ef}, req,
          {13'd0, acc_o, b_o, cy_o, ac_o, ov_o}, {13'd0, ea, eb, ef});
    check(parity_o == ^ea, "R6", {31'd0, parity_o}, {31'd0, ^ea});
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_state("R1 reset", 8'h00, 8'h00, 3'b000);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < N; i++) begin
      {op_i, a_i, b_i, bit_i} = VEC[i][38:19];
      en_i = 1'b1;
      @(negedge clk_i);
      check_state(tag_of(VEC[i][38:36], VEC[i][26:19]),
                  VEC[i][18:11], VEC[i][10:3], VEC[i][2:0]);
    end

    // R11: disabled cycle with an overflowing add presented
    en_i = 1'b0;
    op_i = 3'd0;
    a_i  = 8'hFF;
    b_i  = 8'hFF;
    repeat (2) @(negedge clk_i);
    check_state("R11 en low", 8'h00, 8'h07, 3'b000);

    // R2: add with carry after carry set; odd-parity result for R6
    en_i = 1'b1;
    op_i = 3'd0; a_i = 8'hF0; b_i = 8'h20;
    @(negedge clk_i);
    check_state("R2 carry out", 8'h10, 8'h07, 3'b100);
    op_i = 3'd1; a_i = 8'h03; b_i = 8'h03;
    @(negedge clk_i);
    check_state("R2 addc cin", 8'h07, 8'h07, 3'b000);

    // R1: reset mid-run clears everything
    en_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check_state("R1 async reset", 8'h00, 8'h00, 3'b000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule